// File: doc/BRIEF.md
# Store Address and Exception Checker

This block carries out a word store with an immediate offset for a 32-bit soft processor. It adds a base register to a 16-bit immediate to form the effective address. It then tests that address against three fault rules in a fixed order: translation, zone protection and word alignment. If no rule fires, it issues a single-word write request that carries the source register. If a rule fires, it blocks the write and captures a fault record. The record holds a cause code, a store flag, per-cause detail bits, and the mode bits to be saved and cleared.

An immediate-prefix instruction may come just before the store. Its 16 bits then become the upper half of the immediate in place of the sign extension. The prefix is used up by the next accepted store. The translation result and the zone-protection result come from outside as plain inputs. They are sampled in the cycle the address is checked, and that address is shown on `lookup_addr`.

A parameter selects one of two timings. The performance build produces its result one cycle after issue. The area build registers the operands first and produces its result two cycles after issue. A fault record is held until the exception logic acknowledges it. While a record is held, the block does not accept new stores.

Top module: `store_word_unit`

## Requirements
- R1: The effective address is `base_val + sext(imm_lo)` modulo 2^32, and it appears on `wr_addr` when no fault occurs.
- R2: After a `pfx_load` pulse, the next accepted store uses `{pfx_hi, imm_lo}` as its immediate. The store after that sign-extends again.
- R3: When `cur_vm`=1 and `xlat_hit`=0, a fault is raised with cause 5'b10010, whatever the zone and alignment inputs are.
- R4: When R3 does not apply, `cur_vm`=1, and either `zone_ro`=1 or (`zone_noacc`=1 and `cur_um`=1), a fault is raised with cause 5'b10000. `flt_diz` is 1 exactly when `zone_noacc` and `cur_um` are both 1. `zone_noacc` has no effect when `cur_um`=0.
- R5: When neither R3 nor R4 applies and address bits [1:0] are not 00, a fault is raised with cause 5'b00001, `flt_word`=1 and `flt_reg`=`src_idx`. For the other causes, `flt_word`=0 and `flt_reg`=0.
- R6: Every fault record has `flt_store`=1.
- R7: For causes 5'b10010 and 5'b10000, `flt_mode_upd`=1, `flt_saved_um`=`cur_um` and `flt_saved_vm`=`cur_vm`; `flt_mode_upd`=1 tells the mode logic to clear its live bits. An unaligned fault has `flt_mode_upd`=0 and both saved bits at 0.
- R8: A store with no fault pulses `wr_valid` for exactly one cycle, with `wr_data`=`src_val`.
- R9: With `AREA_OPT`=0, results appear one clock edge after issue. With `AREA_OPT`=1, they appear after two edges, and `ready` is 0 in between.
- R10: `wr_valid` and `flt_valid` are never 1 together. `flt_valid` and its fields stay stable until `flt_ack`. While `flt_valid`=1, `ready`=0 and issued stores are dropped with no write.
- R11: After reset, `wr_valid`=0, `flt_valid`=0 and `ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | A store is presented this cycle |
| base_val | input | 32 | Base register value |
| src_val | input | 32 | Source register value to be stored |
| imm_lo | input | 16 | Immediate field |
| src_idx | input | 5 | Source register number |
| pfx_load | input | 1 | Immediate prefix presented this cycle |
| pfx_hi | input | 16 | Upper immediate bits from the prefix |
| cur_um | input | 1 | Current user-mode bit |
| cur_vm | input | 1 | Current virtual-protected-mode bit |
| xlat_hit | input | 1 | Valid translation found for `lookup_addr` |
| zone_noacc | input | 1 | Zone says no access for `lookup_addr` |
| zone_ro | input | 1 | Zone says read only for `lookup_addr` |
| flt_ack | input | 1 | Fault record consumed |
| ready | output | 1 | Store issue accepted this cycle |
| lookup_addr | output | 32 | Address being checked this cycle |
| wr_valid | output | 1 | Write request pulse |
| wr_addr | output | 32 | Write word address |
| wr_data | output | 32 | Write data |
| flt_valid | output | 1 | Fault record held |
| flt_cause | output | 5 | Fault cause code |
| flt_store | output | 1 | Fault came from a store |
| flt_diz | output | 1 | No-access zone fault |
| flt_word | output | 1 | Word-size access flag on unaligned fault |
| flt_reg | output | 5 | Register number on unaligned fault |
| flt_mode_upd | output | 1 | Clear live mode bits and save them |
| flt_saved_um | output | 1 | Value for the saved user-mode bit |
| flt_saved_vm | output | 1 | Value for the saved virtual-mode bit |

## Verification
The assertions assume that the translation, zone and mode inputs stay steady for the whole cycle in which the address is checked. They also assume that `flt_ack` comes only while a record is held. In the area build, the check happens on the edge after issue. The stimulus therefore holds those inputs over both cycles of every store and raises the acknowledge only after it has seen `flt_valid`. The sweep walks every combination of mode bits, lookup results and low address bits, so every order of priority between the three faults is reached in both timing builds.

// File: rtl/swu_pkg.sv
package swu_pkg;

    localparam int CAUSE_W = 5;

    // Cause codes; the values are decoded by the exception logic.
    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE      = 5'b00000,
        CAUSE_UNALIGNED = 5'b00001,
        CAUSE_DSTORE    = 5'b10000,
        CAUSE_XMISS     = 5'b10010
    } cause_e;

    typedef struct packed {
        logic   valid;
        cause_e cause;
        logic   diz;
        logic   word;
        logic   mode_upd;
    } flt_kind_t;

endpackage

// File: rtl/swu_ea_gen.sv
module swu_ea_gen #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pfx_load,
    input  logic [XLEN-IMM_W-1:0]  pfx_hi,
    input  logic                   consume,
    input  logic [XLEN-1:0]        base,
    input  logic [IMM_W-1:0]       imm_lo,
    output logic [XLEN-1:0]        ea
);
    localparam int HI_W = XLEN - IMM_W;

    typedef struct packed {
        logic            valid;
        logic [HI_W-1:0] hi;
    } pfx_t;

    pfx_t            pfx_d, pfx_q;
    logic [XLEN-1:0] imm_full;

    always_comb begin
        pfx_d = pfx_q;
        if (pfx_load) begin
            pfx_d.valid = 1'b1;
            pfx_d.hi    = pfx_hi;
        end else if (consume) begin
            pfx_d.valid = 1'b0;
        end

        if (pfx_q.valid) begin
            imm_full = {pfx_q.hi, imm_lo};
        end else begin
            imm_full = {{HI_W{imm_lo[IMM_W-1]}}, imm_lo};
        end
        ea = base + imm_full;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pfx_q <= '0;
        end else begin
            pfx_q <= pfx_d;
        end
    end

    // R2: a store accepted without a new prefix leaves no prefix behind
    a_r2_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !pfx_load) |=> !pfx_q.valid);

endmodule

// File: rtl/swu_fault_eval.sv
module swu_fault_eval
    import swu_pkg::*;
(
    input  logic      [1:0] addr_lo,
    input  logic            vm,
    input  logic            um,
    input  logic            xlat_hit,
    input  logic            zone_noacc,
    input  logic            zone_ro,
    output flt_kind_t       kind
);
    logic noacc_eff;

    always_comb begin
        noacc_eff = zone_noacc & um;
        kind      = '0;
        if (vm && !xlat_hit) begin
            kind.valid    = 1'b1;
            kind.cause    = CAUSE_XMISS;
            kind.mode_upd = 1'b1;
        end else if (vm && (noacc_eff || zone_ro)) begin
            kind.valid    = 1'b1;
            kind.cause    = CAUSE_DSTORE;
            kind.diz      = noacc_eff;
            kind.mode_upd = 1'b1;
        end else if (addr_lo != 2'b00) begin
            kind.valid    = 1'b1;
            kind.cause    = CAUSE_UNALIGNED;
            kind.word     = 1'b1;
        end
    end

    always_comb begin
        if (kind.mode_upd === 1'b1) begin
            a_r7_mode_needs_vm: assert (vm === 1'b1);
        end
        if (kind.diz === 1'b1) begin
            a_r4_diz_user_only: assert (um === 1'b1 && zone_noacc === 1'b1);
        end
    end

endmodule

// File: rtl/store_word_unit.sv
module store_word_unit
    import swu_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int IMM_W    = 16,
    parameter int RIDX_W   = 5,
    parameter int AREA_OPT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue_valid,
    input  logic [XLEN-1:0]       base_val,
    input  logic [XLEN-1:0]       src_val,
    input  logic [IMM_W-1:0]      imm_lo,
    input  logic [RIDX_W-1:0]     src_idx,
    input  logic                  pfx_load,
    input  logic [XLEN-IMM_W-1:0] pfx_hi,
    input  logic                  cur_um,
    input  logic                  cur_vm,
    input  logic                  xlat_hit,
    input  logic                  zone_noacc,
    input  logic                  zone_ro,
    input  logic                  flt_ack,
    output logic                  ready,
    output logic [XLEN-1:0]       lookup_addr,
    output logic                  wr_valid,
    output logic [XLEN-1:0]       wr_addr,
    output logic [XLEN-1:0]       wr_data,
    output logic                  flt_valid,
    output logic [CAUSE_W-1:0]    flt_cause,
    output logic                  flt_store,
    output logic                  flt_diz,
    output logic                  flt_word,
    output logic [RIDX_W-1:0]     flt_reg,
    output logic                  flt_mode_upd,
    output logic                  flt_saved_um,
    output logic                  flt_saved_vm
);
    typedef struct packed {
        logic              valid;
        logic [XLEN-1:0]   ea;
        logic [XLEN-1:0]   data;
        logic [RIDX_W-1:0] ridx;
    } op_t;

    typedef struct packed {
        logic              wr_valid;
        logic [XLEN-1:0]   wr_addr;
        logic [XLEN-1:0]   wr_data;
        logic              flt_valid;
        flt_kind_t         kind;
        logic [RIDX_W-1:0] ridx;
        logic              saved_um;
        logic              saved_vm;
    } st_t;

    logic            accept;
    logic            stage_busy;
    logic [XLEN-1:0] ea;
    op_t             op_in, chk_op;
    flt_kind_t       kind;
    st_t             st_d, st_q;

    assign ready  = !st_q.flt_valid && !stage_busy;
    assign accept = issue_valid && ready;

    swu_ea_gen #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W)
    ) u_ea (
        .clk      (clk),
        .rst_n    (rst_n),
        .pfx_load (pfx_load),
        .pfx_hi   (pfx_hi),
        .consume  (accept),
        .base     (base_val),
        .imm_lo   (imm_lo),
        .ea       (ea)
    );

    always_comb begin
        op_in.valid = accept;
        op_in.ea    = ea;
        op_in.data  = src_val;
        op_in.ridx  = src_idx;
    end

    generate
        if (AREA_OPT != 0) begin : g_two_cycle
            op_t op_d, op_q;
            always_comb begin
                op_d = op_in;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    op_q <= '0;
                end else begin
                    op_q <= op_d;
                end
            end
            assign chk_op     = op_q;
            assign stage_busy = op_q.valid;
        end else begin : g_one_cycle
            assign chk_op     = op_in;
            assign stage_busy = 1'b0;
        end
    endgenerate

    assign lookup_addr = chk_op.ea;

    swu_fault_eval u_eval (
        .addr_lo    (chk_op.ea[1:0]),
        .vm         (cur_vm),
        .um         (cur_um),
        .xlat_hit   (xlat_hit),
        .zone_noacc (zone_noacc),
        .zone_ro    (zone_ro),
        .kind       (kind)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wr_valid = 1'b0;
        if (st_q.flt_valid && flt_ack) begin
            st_d.flt_valid = 1'b0;
        end
        if (chk_op.valid) begin
            if (kind.valid) begin
                st_d.flt_valid = 1'b1;
                st_d.kind      = kind;
                st_d.ridx      = kind.word ? chk_op.ridx : '0;
                st_d.saved_um  = kind.mode_upd & cur_um;
                st_d.saved_vm  = kind.mode_upd & cur_vm;
            end else begin
                st_d.wr_valid  = 1'b1;
                st_d.wr_addr   = chk_op.ea;
                st_d.wr_data   = chk_op.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid     = st_q.wr_valid;
    assign wr_addr      = st_q.wr_addr;
    assign wr_data      = st_q.wr_data;
    assign flt_valid    = st_q.flt_valid;
    assign flt_cause    = st_q.kind.cause;
    assign flt_store    = st_q.kind.valid;
    assign flt_diz      = st_q.kind.diz;
    assign flt_word     = st_q.kind.word;
    assign flt_reg      = st_q.ridx;
    assign flt_mode_upd = st_q.kind.mode_upd;
    assign flt_saved_um = st_q.saved_um;
    assign flt_saved_vm = st_q.saved_vm;

    // R10: write and fault never together
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && flt_valid));

    // R10: record held until acknowledged
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_ack) |=> (flt_valid && $stable(flt_cause) && $stable(flt_reg)
                                     && $stable(flt_saved_um) && $stable(flt_saved_vm)));

    // R10: a held record blocks issue and no write follows
    a_r10_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> !ready);

    // R8: writes only go to word-aligned addresses
    a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00));

    // R6: store flag on every record
    a_r6_store_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> flt_store);

    // R3 R4 R5: only the three legal cause codes
    a_r5_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (flt_cause == 5'b10010 || flt_cause == 5'b10000 || flt_cause == 5'b00001));

    // R7: unaligned faults never touch the mode bits
    a_r7_unaligned_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_cause == 5'b00001) |-> (!flt_mode_upd && flt_word));

    // R9: the area build leaves a gap cycle after each accepted store
    a_r9_area_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((AREA_OPT != 0) && issue_valid && ready) |=> !ready);

endmodule

// File: tb/store_word_unit_tb.sv
`timescale 1ns/1ps
module store_word_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [31:0] src_val = '0;
    logic [15:0] imm_lo = '0;
    logic [4:0]  src_idx = '0;
    logic        pfx_load = 1'b0;
    logic [15:0] pfx_hi = '0;
    logic        cur_um = 1'b0;
    logic        cur_vm = 1'b0;
    logic        xlat_hit = 1'b1;
    logic        zone_noacc = 1'b0;
    logic        zone_ro = 1'b0;
    logic        flt_ack = 1'b0;

    logic        ready [2];
    logic [31:0] lookup_addr [2];
    logic        wr_valid [2];
    logic [31:0] wr_addr [2];
    logic [31:0] wr_data [2];
    logic        flt_valid [2];
    logic [4:0]  flt_cause [2];
    logic        flt_store [2];
    logic        flt_diz [2];
    logic        flt_word [2];
    logic [4:0]  flt_reg [2];
    logic        flt_mode_upd [2];
    logic        flt_saved_um [2];
    logic        flt_saved_vm [2];

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    store_word_unit #(.AREA_OPT(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .base_val(base_val),
        .src_val(src_val), .imm_lo(imm_lo), .src_idx(src_idx), .pfx_load(pfx_load),
        .pfx_hi(pfx_hi), .cur_um(cur_um), .cur_vm(cur_vm), .xlat_hit(xlat_hit),
        .zone_noacc(zone_noacc), .zone_ro(zone_ro), .flt_ack(flt_ack),
        .ready(ready[0]), .lookup_addr(lookup_addr[0]), .wr_valid(wr_valid[0]),
        .wr_addr(wr_addr[0]), .wr_data(wr_data[0]), .flt_valid(flt_valid[0]),
        .flt_cause(flt_cause[0]), .flt_store(flt_store[0]), .flt_diz(flt_diz[0]),
        .flt_word(flt_word[0]), .flt_reg(flt_reg[0]), .flt_mode_upd(flt_mode_upd[0]),
        .flt_saved_um(flt_saved_um[0]), .flt_saved_vm(flt_saved_vm[0])
    );

    store_word_unit #(.AREA_OPT(1)) u_dut_area (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .base_val(base_val),
        .src_val(src_val), .imm_lo(imm_lo), .src_idx(src_idx), .pfx_load(pfx_load),
        .pfx_hi(pfx_hi), .cur_um(cur_um), .cur_vm(cur_vm), .xlat_hit(xlat_hit),
        .zone_noacc(zone_noacc), .zone_ro(zone_ro), .flt_ack(flt_ack),
        .ready(ready[1]), .lookup_addr(lookup_addr[1]), .wr_valid(wr_valid[1]),
        .wr_addr(wr_addr[1]), .wr_data(wr_data[1]), .flt_valid(flt_valid[1]),
        .flt_cause(flt_cause[1]), .flt_store(flt_store[1]), .flt_diz(flt_diz[1]),
        .flt_word(flt_word[1]), .flt_reg(flt_reg[1]), .flt_mode_upd(flt_mode_upd[1]),
        .flt_saved_um(flt_saved_um[1]), .flt_saved_vm(flt_saved_vm[1])
    );

    // expected record
    logic        e_flt, e_diz, e_word, e_mupd, e_sum, e_svm;
    logic [4:0]  e_cause, e_reg;
    logic [31:0] e_addr;
    string       e_creq;

    task automatic chk(input string req, input string what, input int k,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s dut%0d: actual=%h expected=%h", req, what, k, act, exp);
        end
    endtask

    task automatic check_result(input int k, input string areq);
        chk("R10", "flt_valid", k, 32'(flt_valid[k]), 32'(e_flt));
        if (e_flt) begin
            chk("R10", "wr_valid in fault", k, 32'(wr_valid[k]), 32'h0);
            chk(e_creq, "flt_cause", k, 32'(flt_cause[k]), 32'(e_cause));
            chk("R6", "flt_store", k, 32'(flt_store[k]), 32'h1);
            chk("R4", "flt_diz", k, 32'(flt_diz[k]), 32'(e_diz));
            chk("R5", "flt_word", k, 32'(flt_word[k]), 32'(e_word));
            chk("R5", "flt_reg", k, 32'(flt_reg[k]), 32'(e_reg));
            chk("R7", "flt_mode_upd", k, 32'(flt_mode_upd[k]), 32'(e_mupd));
            chk("R7", "flt_saved_um", k, 32'(flt_saved_um[k]), 32'(e_sum));
            chk("R7", "flt_saved_vm", k, 32'(flt_saved_vm[k]), 32'(e_svm));
        end else begin
            chk("R8", "wr_valid", k, 32'(wr_valid[k]), 32'h1);
            chk(areq, "wr_addr", k, wr_addr[k], e_addr);
            chk("R8", "wr_data", k, wr_data[k], src_val);
        end
    endtask

    task automatic run_store(input logic [31:0] b, input logic [15:0] imm, input logic [31:0] src,
                             input logic [4:0] idx, input logic um, input logic vm, input logic hit,
                             input logic na, input logic ro, input logic use_pfx,
                             input logic [15:0] ph, input logic pfx_left, input string areq);
        logic [31:0] imm32;
        logic        xm, ds, un, nae;
        logic [4:0]  held_cause;
        if (use_pfx) begin
            pfx_load = 1'b1;
            pfx_hi   = ph;
            @(posedge clk); #1;
            pfx_load = 1'b0;
        end
        imm32  = pfx_left ? {ph, imm} : {{16{imm[15]}}, imm};
        e_addr = b + imm32;
        nae    = na & um;
        xm     = vm & ~hit;
        ds     = vm & (nae | ro);
        un     = (e_addr[1:0] != 2'b00);
        e_flt  = xm | ds | un;
        e_cause = xm ? 5'b10010 : ds ? 5'b10000 : un ? 5'b00001 : 5'b00000;
        e_creq  = xm ? "R3" : ds ? "R4" : "R5";
        e_diz   = !xm && ds && nae;
        e_word  = !xm && !ds && un;
        e_reg   = e_word ? idx : 5'd0;
        e_mupd  = xm | ds;
        e_sum   = e_mupd & um;
        e_svm   = e_mupd & vm;

        base_val = b; imm_lo = imm; src_val = src; src_idx = idx;
        cur_um = um; cur_vm = vm; xlat_hit = hit; zone_noacc = na; zone_ro = ro;
        chk("R10", "ready before issue", 0, 32'(ready[0]), 32'h1);
        chk("R10", "ready before issue", 1, 32'(ready[1]), 32'h1);
        issue_valid = 1'b1;
        @(posedge clk); #1;
        issue_valid = 1'b0;
        check_result(0, areq);
        chk("R9", "area ready in gap", 1, 32'(ready[1]), 32'h0);
        chk("R9", "area wr_valid early", 1, 32'(wr_valid[1]), 32'h0);
        chk("R9", "area flt_valid early", 1, 32'(flt_valid[1]), 32'h0);
        @(posedge clk); #1;
        check_result(1, areq);
        chk("R8", "write is one pulse", 0, 32'(wr_valid[0]), 32'h0);
        chk("R10", "fault still held", 0, 32'(flt_valid[0]), 32'(e_flt));
        if (e_flt) begin
            held_cause = e_cause;
            base_val = 32'h0000_4000; imm_lo = 16'h0010;
            issue_valid = 1'b1;
            @(posedge clk); #1;
            issue_valid = 1'b0;
            @(posedge clk); #1;
            for (int k = 0; k < 2; k++) begin
                chk("R10", "dropped issue no write", k, 32'(wr_valid[k]), 32'h0);
                chk("R10", "cause stable while held", k, 32'(flt_cause[k]), 32'(held_cause));
                chk("R10", "ready low while held", k, 32'(ready[k]), 32'h0);
            end
            flt_ack = 1'b1;
            @(posedge clk); #1;
            flt_ack = 1'b0;
            for (int k = 0; k < 2; k++) begin
                chk("R10", "released by ack", k, 32'(flt_valid[k]), 32'h0);
                chk("R10", "ready after ack", k, 32'(ready[k]), 32'h1);
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog all: actual=timeout expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int k = 0; k < 2; k++) begin
            chk("R11", "reset wr_valid", k, 32'(wr_valid[k]), 32'h0);
            chk("R11", "reset flt_valid", k, 32'(flt_valid[k]), 32'h0);
            chk("R11", "reset ready", k, 32'(ready[k]), 32'h1);
        end

        // full sweep: low address bits x mode bits x lookup results
        for (int c = 0; c < 128; c++) begin
            logic [6:0] v;
            logic       up;
            v  = 7'(c);
            up = (c % 16 == 5);
            run_store(32'h2000_0000 + 32'(c << 8) + 32'(v[1:0]),
                      (v[6] ^ v[1]) ? 16'hFFF0 : 16'h0124,
                      32'hA5A5_0000 ^ 32'(c * 32'h0001_0203), 5'(c + 3),
                      v[3], v[2], v[4], v[5], v[6], up, 16'(c * 3), up,
                      up ? "R2" : "R1");
        end

        // R1 wrap-around and negative immediate
        run_store(32'hFFFF_FFFC, 16'h0004, 32'h1111_2222, 5'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
                  1'b0, 16'h0, 1'b0, "R1");
        run_store(32'h0000_0100, 16'h8000, 32'h3333_4444, 5'd9, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
                  1'b0, 16'h0, 1'b0, "R1");
        // R2 prefix applies once, then sign extension returns
        run_store(32'h0000_0010, 16'h8000, 32'h5555_6666, 5'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
                  1'b1, 16'h1234, 1'b1, "R2");
        run_store(32'h0000_0010, 16'h8000, 32'h7777_8888, 5'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
                  1'b0, 16'h1234, 1'b0, "R2");
        // R4 no-access ignored in supervisor mode
        run_store(32'h0000_0200, 16'h0000, 32'h9999_AAAA, 5'd4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0,
                  1'b0, 16'h0, 1'b0, "R4");
        // R5 unaligned with prefix, highest register index
        run_store(32'h0000_0003, 16'h0000, 32'hBBBB_CCCC, 5'd31, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1,
                  1'b1, 16'h00FF, 1'b1, "R2");

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule